// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Demultiplexer Mode

This block is a small storage register that is loaded one bit at a time. A binary select input chooses one of eight storage cells, and a single serial data line gives that cell its value. A write-block input gates all writing. The eight cells drive eight parallel outputs, and those outputs can be read at any moment, whatever the select and control inputs are doing. There is no clock. Each cell is a level-sensitive latch, and the mode decode is purely combinational.

A clear-request input and the write-block input together choose one of four modes. With both inputs low the block is an addressable latch. With only write-block high it holds its contents. With both high it wipes every bit to zero. With only clear-request high it acts as a 1-of-8 demultiplexer: the selected output follows the serial data line and every other output is forced to zero. The register keeps whatever pattern that mode leaves behind. Typical uses are driving decoded control lines and collecting bits from a successive-approximation loop.

Top module: `addr_latch_demux`

## Requirements
- R1: Select value i (0 to 7, binary on `bit_sel`) addresses the cell that drives `par_out[i]`. All eight outputs are visible in every mode.
- R2: With `clr_req`=0 and `wr_block`=0 (write mode), the addressed output follows `ser_in` for as long as the mode lasts. Every other output keeps its stored value.
- R3: When `wr_block` rises out of write mode, the addressed cell keeps the last `ser_in` value it saw. Later changes on `ser_in` do not reach the outputs.
- R4: With `clr_req`=0 and `wr_block`=1 (hold mode), changes on `bit_sel` and `ser_in` leave all eight outputs unchanged.
- R5: With `clr_req`=1 and `wr_block`=1 (clear mode), all eight outputs are 0, whatever `bit_sel` and `ser_in` are.
- R6: With `clr_req`=1 and `wr_block`=0 (demultiplexer mode), the addressed output equals `ser_in` and all other outputs are 0, whatever they held before.
- R7: When `clr_req` falls out of demultiplexer mode and `wr_block` then rises, the register keeps the demultiplexer pattern: the addressed bit holds the data value and all other bits are 0.
- R8: If `bit_sel` changes during write mode, the newly selected cell follows `ser_in`. The previously selected cell keeps the value it held at the moment of the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clr_req | input | 1 | Clear request. It clears all bits when `wr_block` is high and gives demultiplexer mode when `wr_block` is low |
| wr_block | input | 1 | Write block. High stops all writes into the cells |
| bit_sel | input | ADDR_W (3) | Binary index of the target cell |
| ser_in | input | 1 | Serial data value for the addressed cell |
| par_out | output | 2**ADDR_W (8) | Stored contents, one bit per cell |

## Verification
Demultiplexer mode performs two functions at once: it writes the addressed cell and clears all the others. The bench provokes this by loading several bits in write mode and then raising `clr_req` alone. The expected result is that only the addressed bit survives, holding the data value, and this pattern must persist after the mode is left. Writing and a change of select also fall together when `bit_sel` moves while writes are open. Here the bench changes only the select, with the data held steady. It then checks that the old cell kept its value and the new cell tracks `ser_in`. A scoreboard model built from the mode rules supplies every expected byte.

// File: rtl/al_pkg.sv
package al_pkg;

   // Mode encoding is {clr_req, wr_block}
   typedef enum logic [1:0] {
      AL_WRITE = 2'b00,
      AL_HOLD  = 2'b01,
      AL_DEMUX = 2'b10,
      AL_CLEAR = 2'b11
   } al_mode_e;

   localparam int AL_MAX_ADDR_W = 6;

endpackage

// File: rtl/al_mode_decode.sv
module al_mode_decode
   import al_pkg::*;
(
   input  logic     clr_req,
   input  logic     wr_block,
   output al_mode_e mode,
   output logic     gate_open,
   output logic     wipe_all,
   output logic     strip_rest
);

   always_comb begin
      unique case ({clr_req, wr_block})
         2'b00:   mode = AL_WRITE;
         2'b01:   mode = AL_HOLD;
         2'b10:   mode = AL_DEMUX;
         default: mode = AL_CLEAR;
      endcase
   end

   always_comb begin
      gate_open  = (mode == AL_WRITE) || (mode == AL_DEMUX);
      wipe_all   = (mode == AL_CLEAR);
      strip_rest = (mode == AL_DEMUX);
   end

   // The write gate and the wipe signal never act together
   always_comb begin
      p_gate_vs_wipe_r5: assert (!(gate_open && wipe_all))
         else $error("gate and wipe both active");
   end

endmodule

// File: rtl/al_sel_decode.sv
module al_sel_decode #(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0]      addr,
   output logic [(1<<ADDR_W)-1:0] hit
);

   localparam int NUM_LINES = 1 << ADDR_W;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign hit[i] = (addr == ADDR_W'(i));
   end

   always_comb begin
      if (!$isunknown(addr)) begin
         p_single_hit_r1: assert ($onehot(hit))
            else $error("select decode not one-hot");
      end
   end

endmodule

// File: rtl/al_cell.sv
module al_cell (
   input  logic en,
   input  logic clr,
   input  logic d,
   output logic q
);

   // Clear wins; otherwise the cell is transparent while enabled
   always_latch begin
      if (clr)
         q <= 1'b0;
      else if (en)
         q <= d;
   end

   always_comb begin
      p_no_conflict_r6: assert (!(en && clr))
         else $error("cell enabled and cleared together");
   end

endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
   import al_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic                      clr_req,
   input  logic                      wr_block,
   input  logic [ADDR_W-1:0]         bit_sel,
   input  logic                      ser_in,
   output logic [(1<<ADDR_W)-1:0]    par_out
);

   localparam int NUM_BITS = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > AL_MAX_ADDR_W) begin : g_bad_width
      $error("addr_latch_demux: ADDR_W out of range");
   end

   al_mode_e            mode;
   logic                gate_open;
   logic                wipe_all;
   logic                strip_rest;
   logic [NUM_BITS-1:0] hit;
   logic [NUM_BITS-1:0] bit_en;
   logic [NUM_BITS-1:0] bit_clr;

   al_mode_decode u_mode (
      .clr_req    (clr_req),
      .wr_block   (wr_block),
      .mode       (mode),
      .gate_open  (gate_open),
      .wipe_all   (wipe_all),
      .strip_rest (strip_rest)
   );

   al_sel_decode #(.ADDR_W(ADDR_W)) u_sel (
      .addr (bit_sel),
      .hit  (hit)
   );

   for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
      assign bit_en[i]  = gate_open & hit[i];
      assign bit_clr[i] = wipe_all | (strip_rest & ~hit[i]);

      al_cell u_cell (
         .en  (bit_en[i]),
         .clr (bit_clr[i]),
         .d   (ser_in),
         .q   (par_out[i])
      );
   end

   // Checks on the per-cell controls against the decoded mode
   always_comb begin
      if (!$isunknown({clr_req, wr_block, bit_sel})) begin
         p_one_writer_r2: assert ($onehot0(bit_en))
            else $error("more than one cell open");
         if (mode == AL_HOLD) begin
            p_hold_idle_r4: assert (bit_en == '0 && bit_clr == '0)
               else $error("cell control active in hold");
         end
         if (mode == AL_CLEAR) begin
            p_clear_all_r5: assert (&bit_clr)
               else $error("not every cell cleared");
         end
         if (mode == AL_DEMUX) begin
            p_demux_split_r6: assert ($onehot(bit_en) && ((bit_en | bit_clr) == '1))
               else $error("demux controls incomplete");
         end
      end
   end

endmodule

// File: tb/tb_addr_latch_demux.sv
module tb_addr_latch_demux;

   localparam int AW = 3;
   localparam int NB = 1 << AW;

   logic          clk = 1'b0;
   always #4 clk = ~clk;

   logic          clr_req  = 1'b1;
   logic          wr_block = 1'b1;
   logic [AW-1:0] bit_sel  = '0;
   logic          ser_in   = 1'b0;
   logic [NB-1:0] par_out;

   addr_latch_demux #(.ADDR_W(AW)) dut (
      .clr_req  (clr_req),
      .wr_block (wr_block),
      .bit_sel  (bit_sel),
      .ser_in   (ser_in),
      .par_out  (par_out)
   );

   logic [NB-1:0] model = '0;
   logic [NB-1:0] exp_q[$];
   string         tag_q[$];
   int            n_run  = 0;
   int            n_fail = 0;
   int            cyc    = 0;

   // Monitor: compares the settled outputs with each queued expectation
   always @(posedge clk) begin
      while (exp_q.size() > 0) begin
         logic [NB-1:0] e;
         string         t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_run++;
         if (par_out !== e) begin
            n_fail++;
            $display("FAIL %s: par_out=%b expected %b", t, par_out, e);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected <= 20000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   // Driver: applies one input set, updates the model and queues the result
   task automatic apply(input logic r, input logic w, input logic [AW-1:0] a,
                        input logic d, input string tag);
      @(negedge clk);
      clr_req  = r;
      wr_block = w;
      bit_sel  = a;
      ser_in   = d;
      if (r) begin
         model = '0;
         if (!w) model[a] = d;
      end else if (!w) begin
         model[a] = d;
      end
      exp_q.push_back(model);
      tag_q.push_back(tag);
      @(posedge clk);
      #1;
   endtask

   initial begin
      apply(1'b1, 1'b1, 3'd0, 1'b0, "R5 reset clear");

      // R1 / R8: walk the select with writes open, leaving a trail of ones
      for (int a = 0; a < NB; a++)
         apply(1'b0, 1'b0, AW'(a), 1'b1, "R1 write each address");
      apply(1'b0, 1'b1, 3'd7, 1'b1, "R3 close writes");

      // R4: hold ignores select and data
      for (int a = 0; a < NB; a++)
         apply(1'b0, 1'b1, AW'(a), a[0], "R4 hold ignores inputs");

      // R2 / R3: clear even bits one by one
      for (int a = 0; a < NB; a += 2) begin
         apply(1'b0, 1'b1, AW'(a), 1'b0, "R4 hold setup");
         apply(1'b0, 1'b0, AW'(a), 1'b0, "R2 write zero");
         apply(1'b0, 1'b1, AW'(a), 1'b0, "R3 close after zero");
      end

      // R2: addressed bit tracks data while open
      apply(1'b0, 1'b1, 3'd3, 1'b1, "R4 hold setup");
      apply(1'b0, 1'b0, 3'd3, 1'b1, "R2 open on bit 3");
      apply(1'b0, 1'b0, 3'd3, 1'b0, "R2 follow low");
      apply(1'b0, 1'b0, 3'd3, 1'b1, "R2 follow high");
      apply(1'b0, 1'b0, 3'd3, 1'b0, "R2 follow low again");
      apply(1'b0, 1'b1, 3'd3, 1'b0, "R3 wd rise keeps last");
      apply(1'b0, 1'b1, 3'd3, 1'b1, "R3 data after close ignored");

      // R8: select moves during writing
      apply(1'b0, 1'b0, 3'd3, 1'b1, "R2 reopen bit 3");
      apply(1'b0, 1'b0, 3'd4, 1'b1, "R8 select moves to bit 4");
      apply(1'b0, 1'b0, 3'd4, 1'b0, "R8 old bit kept new bit follows");
      apply(1'b0, 0, 3'd2, 1'b0, "R8 second move");
      apply(1'b0, 1'b1, 3'd2, 1'b0, "R3 close");

      // R5: clear from a non-zero pattern, select sweep ignored
      apply(1'b1, 1'b1, 3'd2, 1'b1, "R5 clear all");
      for (int a = 0; a < NB; a++)
         apply(1'b1, 1'b1, AW'(a), 1'b1, "R5 clear ignores select");

      // R6: demux on every address with both data values
      for (int a = 0; a < NB; a++) begin
         apply(1'b1, 1'b0, AW'(a), 1'b1, "R6 demux data high");
         apply(1'b1, 1'b0, AW'(a), 1'b0, "R6 demux data low");
         apply(1'b1, 1'b0, AW'(a), 1'b1, "R6 demux data high again");
      end

      // R6: entering demux wipes previously stored bits
      apply(1'b0, 1'b1, 3'd1, 1'b1, "R4 hold before reload");
      apply(1'b0, 1'b0, 3'd1, 1'b1, "R2 load bit 1");
      apply(1'b0, 1'b0, 3'd6, 1'b1, "R8 load bit 6");
      apply(1'b1, 1'b0, 3'd6, 1'b1, "R6 others zeroed");

      // R7: leave demux and keep its pattern
      apply(1'b1, 1'b0, 3'd5, 1'b1, "R6 demux bit 5");
      apply(1'b0, 1'b0, 3'd5, 1'b1, "R7 demux exit to write");
      apply(1'b0, 1'b1, 3'd5, 1'b1, "R7 pattern held");
      apply(1'b0, 1'b1, 3'd0, 1'b0, "R7 pattern stable in hold");

      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule